// File: doc/BRIEF.md
# Buffered Synthesizer Control Register Bank

This block is the write side of the control interface of a frequency synthesizer. Bytes arrive one per clock on a valid/data interface, and a flag marks which bytes are instructions. An instruction byte selects one of seven registers. Each register takes its own fixed number of data bytes, sent most significant byte first. When the last byte of a register arrives, the assembled value goes into that register's buffer. The synthesizer core does not see it yet.

A separate update strobe copies every buffered value into the active registers on the same edge. The active registers drive the outputs: two control words, two tuning words, a phase offset and two sweep control words. The second control word is also broken out into its clock-multiplier and range fields, and each sweep word is split into ramp rate and delta. The same update edge raises a one-cycle change flag for each register written since the previous update. Downstream logic, such as a phase-accumulator autoclear, can use these flags.

Top module: `synth_regbank`

## Requirements
- R1: After reset every output, including `chg_pulse`, is zero.
- R2: The instruction byte values map to registers, with data byte counts, as follows: 0x00 control word 1 (4 bytes), 0x01 control word 2 (3), 0x04 tuning word 0 (4), 0x05 phase offset (2), 0x06 tuning word 1 (4), 0x07 down-sweep word (5), 0x08 up-sweep word (5).
- R3: Data bytes are taken MSB-first. The first data byte becomes the most significant byte of the register. Cycles with `byte_vld` low carry no byte.
- R4: A completed write changes no output until `io_update` is sampled high.
- R5: On a clock edge where `io_update` is high, all seven active registers take their buffered values together. The new values are visible after that edge.
- R6: An instruction byte with any other value is ignored. The data bytes that follow it are ignored and change no register.
- R7: An instruction byte that arrives before the current register has all its bytes discards the partial write. The buffered value of that register is unchanged.
- R8: On an update edge, `chg_pulse` goes high for exactly one cycle, with bit i set for each register written since the previous update. The bits in order 0..6 are control 1, control 2, tuning 0, phase offset, tuning 1, down-sweep, up-sweep. Without an update edge, `chg_pulse` is zero.
- R9: `clk_mult` is bits 7..3 of active control word 2, and `vco_hi` is its bit 2. For example, 0x0000A4 gives multiplier 20 with `vco_hi` high.
- R10: For each sweep word, the first data byte is the ramp rate (`*_rate`) and the next four bytes are the delta (`*_delta`).
- R11: Data bytes that arrive after a register is complete, before the next instruction byte, are ignored.
- R12: A write that completes on the same edge as an update is not copied by that update. It stays pending and is copied, and flagged, by the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A byte is present on `byte_dat` |
| byte_is_cmd | input | 1 | The present byte is an instruction byte |
| byte_dat | input | 8 | Byte value |
| io_update | input | 1 | Copy all buffers to the active registers |
| ctl1_word | output | 32 | Active control word 1 |
| ctl2_word | output | 24 | Active control word 2 |
| clk_mult | output | 5 | Clock multiplier field of control word 2 |
| vco_hi | output | 1 | High range select of control word 2 |
| tune0 | output | 32 | Active tuning word 0 |
| phase_ofs | output | 16 | Active phase offset |
| tune1 | output | 32 | Active tuning word 1 |
| dn_rate | output | 8 | Down-sweep ramp rate |
| dn_delta | output | 32 | Down-sweep delta |
| up_rate | output | 8 | Up-sweep ramp rate |
| up_delta | output | 32 | Up-sweep delta |
| chg_pulse | output | 7 | Per-register change flags, one cycle at update |

## Verification
Directed sequences check the main function with known values:
- tuning words, a multiplier setting and sweep words written with and without valid gaps, which separates MSB-first assembly from byte-order or length faults;
- writes followed by idle cycles before the update, which separates buffered behaviour from write-through;
- truncated frames, unmapped instruction bytes and surplus data bytes, which show whether a stray byte can reach a register;
- a write that ends on the update edge, which exposes off-by-one-edge handling of the change flags.

A long random mix of instruction bytes, data bytes, gaps and updates is then compared every cycle with a reference model. This catches interactions the directed cases do not reach.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NREG = 7;
  localparam int MAXB = 5;
  localparam int WMAX = 8 * MAXB;
  localparam int IW   = $clog2(NREG);
  localparam int CW   = $clog2(MAXB + 1);

  typedef logic [WMAX-1:0] word_t;

  // Data byte count per register index
  function automatic int reg_bytes(input int i);
    case (i)
      0: return 4;
      1: return 3;
      2: return 4;
      3: return 2;
      4: return 4;
      5: return 5;
      default: return 5;
    endcase
  endfunction

  // Instruction byte value per register index
  function automatic logic [7:0] reg_addr(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h04;
      3: return 8'h05;
      4: return 8'h06;
      5: return 8'h07;
      default: return 8'h08;
    endcase
  endfunction
endpackage

// File: rtl/regbank_collector.sv
module regbank_collector
  import regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          byte_is_cmd,
  input  logic [7:0]    byte_dat,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output word_t         wr_data
);
  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] left_q, left_d;
  word_t         sh_q, sh_d;
  logic          hit;
  logic [IW-1:0] hit_idx;

  // Instruction decode
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (byte_dat == reg_addr(i)) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  // Next state
  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    left_d  = left_q;
    sh_d    = sh_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    wr_data = {sh_q[WMAX-9:0], byte_dat};
    if (byte_is_cmd) begin
      busy_d = hit;
      idx_d  = hit_idx;
      left_d = CW'(reg_bytes(int'(hit_idx)));
      sh_d   = '0;
    end else if (busy_q) begin
      sh_d   = wr_data;
      left_d = left_q - 1'b1;
      if (left_q == CW'(1)) begin
        busy_d = 1'b0;
        wr_en  = byte_vld;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      sh_q   <= '0;
    end else if (byte_vld) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      sh_q   <= sh_d;
    end
  end

  p_left_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0 && left_q <= CW'(MAXB)));
  p_write_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy_q && !byte_is_cmd));
  p_no_write_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_is_cmd) |=> !wr_en);
endmodule

// File: rtl/regbank_shadow.sv
module regbank_shadow
  import regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  word_t           wr_data,
  input  logic            io_update,
  output word_t           shadow_q [NREG],
  output logic [NREG-1:0] dirty_q
);
  logic [NREG-1:0] sel;
  logic [NREG-1:0] dirty_d;

  for (genvar g = 0; g < NREG; g++) begin : g_buf
    localparam int    W    = 8 * reg_bytes(g);
    localparam word_t MASK = ~(word_t'('1) << W);
    assign sel[g] = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q[g] <= '0;
      else if (sel[g]) shadow_q[g] <= wr_data & MASK;
    end
  end

  always_comb dirty_d = (io_update ? '0 : dirty_q) | sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= '0;
    else        dirty_q <= dirty_d;
  end

  p_dirty_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dirty_q[$past(wr_idx)]);
  p_dirty_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_update && !wr_en) |=> (dirty_q == '0));
  p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow_q[0]) && $stable(shadow_q[5]));
endmodule

// File: rtl/regbank_active.sv
module regbank_active
  import regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_update,
  input  word_t           shadow_q [NREG],
  input  logic [NREG-1:0] dirty_q,
  output word_t           active_q [NREG],
  output logic [NREG-1:0] chg_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q[g] <= '0;
      else if (io_update) active_q[g] <= shadow_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= io_update ? dirty_q : '0;
  end

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> ($stable(active_q[2]) && $stable(active_q[6])));
  p_pulse_needs_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> (chg_q == '0));
endmodule

// File: rtl/synth_regbank.sv
module synth_regbank
  import regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_is_cmd,
  input  logic [7:0]  byte_dat,
  input  logic        io_update,
  output logic [31:0] ctl1_word,
  output logic [23:0] ctl2_word,
  output logic [4:0]  clk_mult,
  output logic        vco_hi,
  output logic [31:0] tune0,
  output logic [15:0] phase_ofs,
  output logic [31:0] tune1,
  output logic [7:0]  dn_rate,
  output logic [31:0] dn_delta,
  output logic [7:0]  up_rate,
  output logic [31:0] up_delta,
  output logic [6:0]  chg_pulse
);
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  word_t           wr_data;
  word_t           shadow_q [NREG];
  word_t           active_q [NREG];
  logic [NREG-1:0] dirty_q;
  logic [NREG-1:0] chg_q;

  regbank_collector u_coll (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_is_cmd(byte_is_cmd),
    .byte_dat(byte_dat), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  regbank_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .io_update(io_update), .shadow_q(shadow_q), .dirty_q(dirty_q));

  regbank_active u_active (
    .clk(clk), .rst_n(rst_n), .io_update(io_update), .shadow_q(shadow_q),
    .dirty_q(dirty_q), .active_q(active_q), .chg_q(chg_q));

  assign ctl1_word = active_q[0][31:0];
  assign ctl2_word = active_q[1][23:0];
  assign clk_mult  = active_q[1][7:3];
  assign vco_hi    = active_q[1][2];
  assign tune0     = active_q[2][31:0];
  assign phase_ofs = active_q[3][15:0];
  assign tune1     = active_q[4][31:0];
  assign dn_rate   = active_q[5][39:32];
  assign dn_delta  = active_q[5][31:0];
  assign up_rate   = active_q[6][39:32];
  assign up_delta  = active_q[6][31:0];
  assign chg_pulse = 7'(chg_q);
endmodule

// File: tb/synth_regbank_bench.sv
module synth_regbank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0, byte_is_cmd = 1'b0, io_update = 1'b0;
  logic [7:0] byte_dat = 8'h00;
  logic [31:0] ctl1_word, tune0, tune1, dn_delta, up_delta;
  logic [23:0] ctl2_word;
  logic [4:0]  clk_mult;
  logic        vco_hi;
  logic [15:0] phase_ofs;
  logic [7:0]  dn_rate, up_rate;
  logic [6:0]  chg_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  synth_regbank u_synth_regbank (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_is_cmd(byte_is_cmd),
    .byte_dat(byte_dat), .io_update(io_update), .ctl1_word(ctl1_word),
    .ctl2_word(ctl2_word), .clk_mult(clk_mult), .vco_hi(vco_hi), .tune0(tune0),
    .phase_ofs(phase_ofs), .tune1(tune1), .dn_rate(dn_rate), .dn_delta(dn_delta),
    .up_rate(up_rate), .up_delta(up_delta), .chg_pulse(chg_pulse));

  // Reference model state
  logic [39:0] m_buf [7];
  logic [39:0] m_act [7];
  logic [39:0] m_sh;
  logic [6:0]  m_dirty, m_pulse;
  bit          m_busy;
  int          m_idx, m_left;

  function automatic int blen(input int i);
    case (i)
      0: return 4; 1: return 3; 2: return 4; 3: return 2;
      4: return 4; default: return 5;
    endcase
  endfunction

  function automatic int lookup(input logic [7:0] b);
    case (b)
      8'h00: return 0; 8'h01: return 1; 8'h04: return 2; 8'h05: return 3;
      8'h06: return 4; 8'h07: return 5; 8'h08: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [228:0] exp_vec();
    return {m_act[0][31:0], m_act[1][23:0], m_act[1][7:3], m_act[1][2],
            m_act[2][31:0], m_act[3][15:0], m_act[4][31:0], m_act[5][39:32],
            m_act[5][31:0], m_act[6][39:32], m_act[6][31:0], m_pulse};
  endfunction

  function automatic logic [228:0] act_vec();
    return {ctl1_word, ctl2_word, clk_mult, vco_hi, tune0, phase_ofs, tune1,
            dn_rate, dn_delta, up_rate, up_delta, chg_pulse};
  endfunction

  task automatic check_all(input string tag);
    checks++;
    if (act_vec() !== exp_vec()) begin
      errors++;
      $display("FAIL %s: outputs actual=%h expected=%h", tag, act_vec(), exp_vec());
    end
  endtask

  task automatic check_val(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input bit vld, input bit cmd, input logic [7:0] dat,
                      input bit upd, input string tag);
    logic [6:0] nd;
    byte_vld = vld; byte_is_cmd = cmd; byte_dat = dat; io_update = upd;
    @(posedge clk);
    m_pulse = upd ? m_dirty : 7'd0;
    nd = upd ? 7'd0 : m_dirty;
    if (upd) for (int i = 0; i < 7; i++) m_act[i] = m_buf[i];
    if (vld) begin
      if (cmd) begin
        m_idx  = lookup(dat);
        m_busy = (m_idx >= 0);
        m_left = m_busy ? blen(m_idx) : 0;
        m_sh   = '0;
      end else if (m_busy) begin
        m_sh = {m_sh[31:0], dat};
        m_left--;
        if (m_left == 0) begin
          m_busy = 1'b0;
          m_buf[m_idx] = m_sh;
          nd[m_idx] = 1'b1;
        end
      end
    end
    m_dirty = nd;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr_reg(input logic [7:0] addr, input int n, input logic [39:0] v,
                        input string tag);
    step(1, 1, addr, 0, tag);
    for (int k = n - 1; k >= 0; k--) step(1, 0, v[8*k +: 8], 0, tag);
  endtask

  task automatic upd(input string tag);
    step(0, 0, 8'h00, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 7; i++) begin m_buf[i] = '0; m_act[i] = '0; end
    m_sh = '0; m_dirty = '0; m_pulse = '0; m_busy = 0; m_idx = 0; m_left = 0;
    repeat (3) @(negedge clk);
    check_val("R1 reset outputs", {11'd0, act_vec()}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R3/R4: tuning word 0 MSB-first, held until update
    wr_reg(8'h04, 4, 40'h4E147AE1, "R4 before update");
    step(0, 0, 8'h00, 0, "R4 idle");
    check_val("R4 tune0 still old", {8'd0, tune0}, 40'd0);
    upd("R5 update");
    check_val("R3 tune0 msb first", {8'd0, tune0}, 40'h4E147AE1);
    check_val("R8 pulse tune0", {33'd0, chg_pulse}, 40'h04);
    step(0, 0, 8'h00, 0, "R8 pulse ends");
    check_val("R8 pulse one cycle", {33'd0, chg_pulse}, 40'h00);

    // R9: control word 2 fields; R3 with valid gaps
    step(1, 1, 8'h01, 0, "R3");
    step(1, 0, 8'h00, 0, "R3");
    step(0, 0, 8'hFF, 0, "R3 gap");
    step(1, 0, 8'h00, 0, "R3");
    step(0, 1, 8'h05, 0, "R3 gap cmd");
    step(1, 0, 8'hA4, 0, "R3");
    // R10: sweep words
    wr_reg(8'h08, 5, 40'h010001A36F, "R10");
    wr_reg(8'h07, 5, 40'h0100001BF4, "R10");
    wr_reg(8'h00, 4, 40'h00000020, "R2");
    wr_reg(8'h05, 2, 40'h0800, "R2");
    wr_reg(8'h06, 4, 40'h2825AEE6, "R2");
    upd("R5 all at once");
    check_val("R9 clk_mult", {35'd0, clk_mult}, 40'd20);
    check_val("R9 vco_hi", {39'd0, vco_hi}, 40'd1);
    check_val("R10 up_rate", {32'd0, up_rate}, 40'h01);
    check_val("R10 up_delta", {8'd0, up_delta}, 40'h0001A36F);
    check_val("R10 dn_delta", {8'd0, dn_delta}, 40'h00001BF4);
    check_val("R8 pulse set", {33'd0, chg_pulse}, 40'h7B);

    // R7: partial write discarded
    step(1, 1, 8'h04, 0, "R7");
    step(1, 0, 8'hDE, 0, "R7");
    step(1, 0, 8'hAD, 0, "R7");
    wr_reg(8'h05, 2, 40'h1234, "R7");
    upd("R7");
    check_val("R7 tune0 kept", {8'd0, tune0}, 40'h4E147AE1);
    check_val("R7 phase written", {24'd0, phase_ofs}, 40'h1234);

    // R6: unmapped instruction, following data ignored
    step(1, 1, 8'h02, 0, "R6");
    for (int k = 0; k < 6; k++) step(1, 0, 8'h5A, 0, "R6");
    step(1, 1, 8'h88, 0, "R6");
    for (int k = 0; k < 5; k++) step(1, 0, 8'hC3, 0, "R6");
    upd("R6");
    check_val("R6 no change flags", {33'd0, chg_pulse}, 40'h00);
    check_val("R6 ctl1 kept", {8'd0, ctl1_word}, 40'h20);

    // R11: surplus data bytes after completion
    wr_reg(8'h05, 2, 40'h0800, "R11");
    step(1, 0, 8'hEE, 0, "R11");
    step(1, 0, 8'hEE, 0, "R11");
    upd("R11");
    check_val("R11 phase not shifted", {24'd0, phase_ofs}, 40'h0800);

    // R12: write completing on the update edge stays pending
    step(1, 1, 8'h06, 0, "R12");
    step(1, 0, 8'h11, 0, "R12");
    step(1, 0, 8'h22, 0, "R12");
    step(1, 0, 8'h33, 0, "R12");
    step(1, 0, 8'h44, 1, "R12 same edge");
    check_val("R12 tune1 old", {8'd0, tune1}, 40'h2825AEE6);
    check_val("R12 no flag yet", {33'd0, chg_pulse}, 40'h00);
    upd("R12 next update");
    check_val("R12 tune1 new", {8'd0, tune1}, 40'h11223344);
    check_val("R12 flag", {33'd0, chg_pulse}, 40'h10);

    // Random mix against the model
    for (int n = 0; n < 6000; n++) begin
      bit v, c, u;
      logic [7:0] d;
      int r;
      v = ($urandom_range(0, 9) < 8);
      c = ($urandom_range(0, 9) < 2);
      u = ($urandom_range(0, 19) == 0);
      r = $urandom_range(0, 9);
      if (c && r < 8) d = (r == 7) ? 8'h08 : ((r < 2) ? 8'(r) : 8'(r + 2));
      else d = 8'($urandom);
      step(v, c, d, u, "R2 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule